// File: doc/BRIEF.md
# Programmable Symbol-Class Automaton Array

This block runs a nondeterministic automaton over a byte stream. It holds a fixed number of identical state elements. Each element owns a 256-bit acceptance mask, a start flag, a report flag and one row of a successor matrix. On every cycle that carries a valid byte, the elements that are enabled all test that byte against their masks at once. An element whose mask accepts the byte becomes active. On the next symbol it enables every element named in its successor row.

Character classes live on the states rather than on the edges. Any set of byte values therefore costs exactly one element. Start-flagged elements are enabled on every symbol, so a pattern can begin at any offset in the stream. When a report-flagged element becomes active, a registered per-element report bit and a single match strobe are raised for one cycle.

The configuration is loaded one element per write while the stream is idle. A synchronous flush clears the active state and leaves the stored configuration unchanged.

Top module: `nfa_array`

## Requirements
- R1: Exactly one symbol is consumed per clock cycle in which `sym_valid_i` is high. In a cycle with `sym_valid_i` low and no flush, `active_o` keeps its value.
- R2: Bit k of an element's mask (bits 0 to 255) accepts byte value k. An enabled element becomes active on a symbol only if the mask bit indexed by that symbol is set.
- R3: A start-flagged element is enabled on every valid symbol, whatever the current active state, so matches can begin at any stream offset.
- R4: Bit j of the successor row written for element i means that, while element i is active, element j is enabled for the next valid symbol. An element with no start flag and no active predecessor stays inactive.
- R5: An activation never propagates within a cycle. A successor of an element that becomes active on symbol t examines only symbol t+1 or later.
- R6: `report_o[j]` is high in the cycle after a valid symbol that made report-flagged element j active. It is low in any cycle after a cycle with no valid symbol. `match_o` is high exactly when any bit of `report_o` is high.
- R7: A high `flush_i` clears `active_o`, `report_o` and `match_o` at the next edge. It takes priority over a valid symbol in the same cycle, and the stored configuration is kept.
- R8: A configuration write (`cfg_we_i` high) is ignored in a cycle where `sym_valid_i` is high. It is accepted otherwise, and its effect applies from the next cycle.
- R9: After reset, all outputs are zero and every element holds an all-zero mask with no flags and an empty successor row, so no element can activate.
- R10: A report bit is never high while the matching active bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Element index addressed by the write |
| cfg_mask_i | input | 256 | Acceptance mask, bit k for byte value k |
| cfg_start_i | input | 1 | Start flag for the element |
| cfg_report_i | input | 1 | Report flag for the element |
| cfg_succ_i | input | N | Successor row: bit j enables element j |
| sym_valid_i | input | 1 | Symbol valid |
| sym_i | input | 8 | Stream symbol |
| flush_i | input | 1 | Synchronous clear of the active state |
| active_o | output | N | Active element vector |
| report_o | output | N | Registered report vector |
| match_o | output | 1 | Registered match strobe |

## Verification
The hardest state to reach from the ports is a chain that is half-walked when something disturbs it. Examples are a flush between two pattern bytes, an idle gap inside a pattern, and a configuration write issued while a byte is valid. The stimulus programs a literal chain, a self-looping digit class and a mask holding only the extreme byte values. It then walks these with gaps, flushes and blocked writes placed mid-pattern. A long random stream over a small alphabet follows, to build overlapping partial matches. A behavioural model predicts every output on every cycle.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  localparam int unsigned SYM_W = 8;
  localparam int unsigned SYM_N = 1 << SYM_W;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [SYM_N-1:0] sym_mask_t;

  typedef struct packed {
    sym_mask_t mask;
    logic      start;
    logic      report;
  } elem_cfg_t;
endpackage

// File: rtl/nfa_cfg_dec.sv
module nfa_cfg_dec #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             stream_busy_i,
  output logic [N-1:0]     wr_o
);
  // writes are blocked while a symbol is being consumed
  logic we_ok;
  assign we_ok = we_i & ~stream_busy_i;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign wr_o[g] = we_ok && (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/nfa_route.sv
module nfa_route #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0]         active_i,
  input  logic [N-1:0]         start_i,
  input  logic [N-1:0][N-1:0]  succ_i,    // succ_i[src][dst]
  output logic [N-1:0]         enable_o
);
  for (genvar d = 0; d < N; d++) begin : g_dst
    logic [N-1:0] col;
    for (genvar s = 0; s < N; s++) begin : g_src
      assign col[s] = succ_i[s][d];
    end
    assign enable_o[d] = start_i[d] | (|(active_i & col));
  end
endmodule

// File: rtl/nfa_elem.sv
module nfa_elem
  import nfa_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cfg_wr_i,
  input  elem_cfg_t cfg_i,
  input  logic [N-1:0] succ_i,
  input  logic      enable_i,
  input  logic      sym_valid_i,
  input  sym_t      sym_i,
  input  logic      flush_i,
  output logic      active_o,
  output logic      report_o,
  output logic      rep_nxt_o,
  output logic      start_o,
  output logic [N-1:0] succ_o
);
  elem_cfg_t    cfg_q;
  logic [N-1:0] succ_q;
  logic         act_q, rep_q;
  logic         hit, act_nxt;

  assign hit     = cfg_q.mask[sym_i];
  assign act_nxt = enable_i & hit;
  assign rep_nxt_o = sym_valid_i & ~flush_i & act_nxt & cfg_q.report;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      succ_q <= '0;
    end else if (cfg_wr_i) begin
      cfg_q  <= cfg_i;
      succ_q <= succ_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      rep_q <= 1'b0;
    end else if (flush_i) begin
      act_q <= 1'b0;
      rep_q <= 1'b0;
    end else if (sym_valid_i) begin
      act_q <= act_nxt;
      rep_q <= act_nxt & cfg_q.report;
    end else begin
      rep_q <= 1'b0;
    end
  end

  assign active_o = act_q;
  assign report_o = rep_q;
  assign start_o  = cfg_q.start;
  assign succ_o   = succ_q;
endmodule

// File: rtl/nfa_array.sv
module nfa_array
  import nfa_pkg::*;
#(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [SYM_N-1:0] cfg_mask_i,
  input  logic             cfg_start_i,
  input  logic             cfg_report_i,
  input  logic [N-1:0]     cfg_succ_i,
  input  logic             sym_valid_i,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             flush_i,
  output logic [N-1:0]     active_o,
  output logic [N-1:0]     report_o,
  output logic             match_o
);
  logic [N-1:0]        wr;
  logic [N-1:0]        enable;
  logic [N-1:0]        start;
  logic [N-1:0]        rep_nxt;
  logic [N-1:0][N-1:0] succ;
  elem_cfg_t           cfg_word;
  logic                match_q;

  assign cfg_word = '{mask: cfg_mask_i, start: cfg_start_i, report: cfg_report_i};

  nfa_cfg_dec #(.N(N), .IDX_W(IDX_W)) i_dec (
    .we_i          (cfg_we_i),
    .idx_i         (cfg_idx_i),
    .stream_busy_i (sym_valid_i),
    .wr_o          (wr)
  );

  nfa_route #(.N(N)) i_route (
    .active_i (active_o),
    .start_i  (start),
    .succ_i   (succ),
    .enable_o (enable)
  );

  for (genvar g = 0; g < N; g++) begin : g_elem
    nfa_elem #(.N(N)) i_elem (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_wr_i    (wr[g]),
      .cfg_i       (cfg_word),
      .succ_i      (cfg_succ_i),
      .enable_i    (enable[g]),
      .sym_valid_i (sym_valid_i),
      .sym_i       (sym_i),
      .flush_i     (flush_i),
      .active_o    (active_o[g]),
      .report_o    (report_o[g]),
      .rep_nxt_o   (rep_nxt[g]),
      .start_o     (start[g]),
      .succ_o      (succ[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= |rep_nxt;
  end

  assign match_o = match_q;
endmodule

// File: rtl/nfa_array_chk.sv
module nfa_array_chk #(
  parameter int unsigned N = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         sym_valid_i,
  input logic         flush_i,
  input logic [N-1:0] active_o,
  input logic [N-1:0] report_o,
  input logic         match_o
);
  assert_rep_implies_act_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (report_o & ~active_o) == '0);

  assert_match_tracks_rep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o == (|report_o));

  assert_idle_no_report_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_i |=> (report_o == '0) && !match_o);

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sym_valid_i && !flush_i) |=> $stable(active_o));

  assert_flush_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (active_o == '0) && (report_o == '0) && !match_o);
endmodule

bind nfa_array nfa_array_chk #(.N(N)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sym_valid_i (sym_valid_i),
  .flush_i     (flush_i),
  .active_o    (active_o),
  .report_o    (report_o),
  .match_o     (match_o)
);

// File: tb/test_nfa_array.sv
`timescale 1ns/1ps
module test_nfa_array;
  localparam int N = 16;
  localparam int IDX_W = $clog2(N);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [IDX_W-1:0] cfg_idx_i = '0;
  logic [255:0]     cfg_mask_i = '0;
  logic             cfg_start_i = 1'b0;
  logic             cfg_report_i = 1'b0;
  logic [N-1:0]     cfg_succ_i = '0;
  logic             sym_valid_i = 1'b0;
  logic [7:0]       sym_i = '0;
  logic             flush_i = 1'b0;
  logic [N-1:0]     active_o;
  logic [N-1:0]     report_o;
  logic             match_o;

  int vectors = 0;
  int errors  = 0;

  // behavioural reference state
  logic [255:0] m_mask [N];
  logic [N-1:0] m_start, m_rep, m_act, m_rpt;
  logic [N-1:0] m_succ [N];

  always #5 clk_i = ~clk_i;

  nfa_array #(.N(N)) i_nfa_array (.*);

  function automatic logic [255:0] cls(string s);
    logic [255:0] m = '0;
    for (int k = 0; k < s.len(); k++) m[s[k]] = 1'b1;
    return m;
  endfunction

  task automatic check(string tag, logic [N-1:0] act_e, logic [N-1:0] rep_e);
    vectors++;
    if (active_o !== act_e) begin
      errors++;
      $display("FAIL %s active_o actual %h expected %h", tag, active_o, act_e);
    end
    if (report_o !== rep_e) begin
      errors++;
      $display("FAIL %s report_o actual %h expected %h", tag, report_o, rep_e);
    end
    if (match_o !== (|rep_e)) begin
      errors++;
      $display("FAIL %s match_o actual %b expected %b", tag, match_o, |rep_e);
    end
  endtask

  // one cycle: inputs already driven after a falling edge
  task automatic tick(string tag);
    logic [N-1:0] en, nx;
    @(posedge clk_i);
    #1;
    for (int j = 0; j < N; j++) begin
      en[j] = m_start[j];
      for (int i = 0; i < N; i++) if (m_act[i] && m_succ[i][j]) en[j] = 1'b1;
      nx[j] = en[j] && m_mask[j][sym_i];
    end
    if (flush_i) begin
      m_act = '0; m_rpt = '0;
    end else if (sym_valid_i) begin
      m_act = nx; m_rpt = nx & m_rep;
    end else begin
      m_rpt = '0;
    end
    if (cfg_we_i && !sym_valid_i) begin
      m_mask[cfg_idx_i]  = cfg_mask_i;
      m_start[cfg_idx_i] = cfg_start_i;
      m_rep[cfg_idx_i]   = cfg_report_i;
      m_succ[cfg_idx_i]  = cfg_succ_i;
    end
    check(tag, m_act, m_rpt);
    @(negedge clk_i);
    cfg_we_i = 1'b0; sym_valid_i = 1'b0; flush_i = 1'b0;
  endtask

  task automatic feed(logic v, logic [7:0] s, logic f, string tag);
    sym_valid_i = v; sym_i = s; flush_i = f;
    tick(tag);
  endtask

  task automatic feed_str(string s, string tag);
    for (int k = 0; k < s.len(); k++) feed(1'b1, s[k], 1'b0, tag);
  endtask

  task automatic cfg(int idx, logic [255:0] m, logic st, logic rp, logic [N-1:0] sc,
                     logic v, string tag);
    cfg_we_i = 1'b1; cfg_idx_i = IDX_W'(idx); cfg_mask_i = m;
    cfg_start_i = st; cfg_report_i = rp; cfg_succ_i = sc;
    sym_valid_i = v; sym_i = "a"; flush_i = 1'b0;
    tick(tag);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    string alpha;
    for (int j = 0; j < N; j++) begin m_mask[j] = '0; m_succ[j] = '0; end
    m_start = '0; m_rep = '0; m_act = '0; m_rpt = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R9 reset", '0, '0);
    // R9: unconfigured array stays silent
    feed_str("a\xff", "R9");

    // R4 R5: literal chain a -> b -> c, report on c
    cfg(0, cls("a"), 1'b1, 1'b0, N'(1 << 1), 1'b0, "R8 cfg");
    cfg(1, cls("b"), 1'b0, 1'b0, N'(1 << 2), 1'b0, "R8 cfg");
    cfg(2, cls("c"), 1'b0, 1'b1, '0,         1'b0, "R8 cfg");
    feed_str("xabcabc", "R4");
    feed_str("acb", "R5");
    // R3: pattern starting at several offsets, overlapping
    feed_str("aabcbabc", "R3");

    // R2: class of digits looping on itself, then ';'
    cfg(3, cls("0123456789"), 1'b1, 1'b0, N'((1 << 3) | (1 << 4)), 1'b0, "R8 cfg");
    cfg(4, cls(";"), 1'b0, 1'b1, '0, 1'b0, "R8 cfg");
    feed_str("12;9x;7;", "R2");
    // R2: mask holding only extreme byte values 0 and 255
    cfg(5, 256'(1) | (256'(1) << 255), 1'b1, 1'b1, '0, 1'b0, "R8 cfg");
    feed(1'b1, 8'h00, 1'b0, "R2 low");
    feed(1'b1, 8'hff, 1'b0, "R2 high");
    feed(1'b1, 8'h01, 1'b0, "R2 miss");
    feed(1'b1, 8'hfe, 1'b0, "R2 miss");

    // R8: write during a valid symbol must be ignored
    cfg(6, '1, 1'b1, 1'b1, '0, 1'b1, "R8 blocked");
    feed_str("qz", "R8 effect");

    // R1: idle gaps inside a pattern
    feed(1'b1, "a", 1'b0, "R1");
    feed(1'b0, "q", 1'b0, "R1 gap");
    feed(1'b0, "q", 1'b0, "R1 gap");
    feed(1'b1, "b", 1'b0, "R1");
    feed(1'b0, "z", 1'b0, "R6 idle");
    feed(1'b1, "c", 1'b0, "R6 report");
    feed(1'b0, "c", 1'b0, "R6 clear");

    // R7: flush mid-pattern, flush beats a valid symbol, config survives
    feed_str("ab", "R7");
    feed(1'b1, "c", 1'b1, "R7 flush");
    feed_str("c", "R7 after");
    feed_str("abc", "R7 config kept");
    // R10: report only with its active bit (compared through report/active pairs)
    feed_str("5;", "R10");

    // random stream mixing everything
    alpha = "abc12;x";
    for (int k = 0; k < 400; k++) begin
      logic v, f;
      logic [7:0] s;
      v = ($urandom % 4) != 0;
      f = ($urandom % 40) == 0;
      s = ($urandom % 16 == 0) ? 8'(($urandom % 2) * 255) : alpha[$urandom % alpha.len()];
      feed(v, s, f, "R4 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule